// File: doc/BRIEF.md
# Outbound PCIe Address Translator

This block sits between a local bus master and the outbound side of a PCIe core. A local address that falls inside a reserved local region is mapped onto a window. Every window has the same power-of-two size, set by a small size index in megabytes. The block swaps the window-selecting upper part of the address for a programmed 64-bit PCIe base and keeps the in-window offset.

Software programs the block through a 32-bit valid/ready register port. That port gives access to the following:
- a command word, where one bit turns translation on and another bit drives the link-training enable;
- a config-routing word, which supplies bus, device, function and a Type 1 flag for configuration accesses;
- the size index;
- a low and a high word for each window.

While translation is off, addresses pass through unchanged. While it is on, an address that does not land on an enabled window is flagged as a miss.

Top module: `obx_top`

## Requirements
- R1: After reset, `out_valid`, `out_miss`, `link_train_en` and all config-routing outputs are 0, and every register reads back 0.
- R2: `reg_ready` is always 1. A read accepted on one edge returns `rd_valid`=1 with its data after that edge. The command (0x004), config (0x008) and window words read back the last value written. The size register (0x030) reads back bits 2:0 only, zero-extended. Any other offset reads 0, and writes to it change nothing.
- R3: Command bit 1 enables translation and command bit 0 drives `link_train_en`. A write sets all 32 command bits as written, so software keeps a bit by rewriting it.
- R4: With command bit 1 clear, a request returns `out_addr` = {32'h0, `req_addr`} and `out_miss` = 0.
- R5: With size index s in bits 2:0 of 0x030, each window spans 2^(20+s) bytes. The window number is (`req_addr` − REGION_BASE) >> (20+s).
- R6: Window n has its low word at 0x200+8n and its high word at 0x204+8n. Bit 0 of the low word enables the window. A hit returns {high, low with bit 0 cleared} + ((`req_addr` − REGION_BASE) mod window size), as a 64-bit sum.
- R7: With translation on, a request is a miss when it lies below REGION_BASE, when its window number is NUM_WIN or more, or when its window is disabled. A miss returns `out_miss`=1 and `out_addr`=0.
- R8: Every request accepted with `req_valid` produces exactly one result with `out_valid`=1 on the following cycle. `out_valid` is 0 at all other times.
- R9: A register write affects requests sampled on later clock edges. A request sampled on the same edge as the write still uses the old setting.
- R10: The config word drives `cfg_bus` from bits 23:16, `cfg_dev` from bits 12:8, `cfg_func` from bits 2:0 and `cfg_type1` from bit 24. These outputs change only after a write to 0x008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register access request |
| reg_ready | output | 1 | Register port ready (always 1) |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Local address |
| out_valid | output | 1 | Result valid |
| out_addr | output | 64 | Translated PCIe address |
| out_miss | output | 1 | No enabled window matched |
| cfg_bus | output | 8 | Config bus number |
| cfg_dev | output | 5 | Config device number |
| cfg_func | output | 3 | Config function number |
| cfg_type1 | output | 1 | Config Type 1 select |
| link_train_en | output | 1 | Link-training enable bit of the command word |

## Verification
Requests are sent in several patterns:
- with translation off, to show the address passes through;
- into an enabled window with a 64-bit base, to show that the high word and the in-window offset both take part;
- into a second window, to show that the window index is decoded;
- into a disabled window, above the last window and below the region, to tell the three kinds of miss apart.

The size index is then changed, and the same offset moves into a different window. A write placed on the same edge as a request, and again one edge before a request, pins down when a new setting takes effect. Register read-back covers the size-field truncation and offsets that map to nothing.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_CMD  = 12'h004;
  localparam logic [REG_AW-1:0] OFS_CFG  = 12'h008;
  localparam logic [REG_AW-1:0] OFS_SIZE = 12'h030;
  localparam logic [REG_AW-1:0] OFS_WIN  = 12'h200;
  localparam int CMD_LINK_BIT = 0;
  localparam int CMD_XLAT_BIT = 1;
  localparam int MB_SHIFT     = 20;

  typedef struct packed {
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic       type1;
  } cfg_route_t;
endpackage

// File: rtl/obx_ctrl_regs.sv
module obx_ctrl_regs
  import obx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              xlat_en,
  output logic              link_en,
  output logic [2:0]        size_idx,
  output cfg_route_t        route,
  output logic              rd_hit,
  output logic [31:0]       rd_val
);
  logic [31:0] cmd_q;
  logic [31:0] cfg_q;
  logic [2:0]  size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      cfg_q  <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      if (addr == OFS_CMD)  cmd_q  <= wdata;
      if (addr == OFS_CFG)  cfg_q  <= wdata;
      if (addr == OFS_SIZE) size_q <= wdata[2:0];
    end
  end

  always_comb begin
    rd_hit = 1'b1;
    rd_val = '0;
    if (addr == OFS_CMD)       rd_val = cmd_q;
    else if (addr == OFS_CFG)  rd_val = cfg_q;
    else if (addr == OFS_SIZE) rd_val = {29'b0, size_q};
    else                       rd_hit = 1'b0;
  end

  assign xlat_en     = cmd_q[CMD_XLAT_BIT];
  assign link_en     = cmd_q[CMD_LINK_BIT];
  assign size_idx    = size_q;
  assign route.bus   = cfg_q[23:16];
  assign route.dev   = cfg_q[12:8];
  assign route.func  = cfg_q[2:0];
  assign route.type1 = cfg_q[24];
endmodule

// File: rtl/obx_win_table.sv
module obx_win_table
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 8,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int WIN_SPAN = 8 * NUM_WIN
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [IDX_W-1:0]  lkp_idx,
  output logic [31:0]       lkp_lo,
  output logic [31:0]       lkp_hi,
  output logic              rd_hit,
  output logic [31:0]       rd_val
);
  logic [31:0] lo_mem [NUM_WIN];
  logic [31:0] hi_mem [NUM_WIN];

  logic [REG_AW-1:0] woff;
  logic              win_sel;
  logic [IDX_W-1:0]  wn;
  logic              upper;

  assign woff    = addr - OFS_WIN;
  assign win_sel = (addr >= OFS_WIN) && (woff < REG_AW'(WIN_SPAN)) && (woff[1:0] == 2'b00);
  assign wn      = woff[IDX_W+2:3];
  assign upper   = woff[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_WIN; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
      end
    end else if (wr_en && win_sel) begin
      if (upper) hi_mem[wn] <= wdata;
      else       lo_mem[wn] <= wdata;
    end
  end

  assign lkp_lo = lo_mem[lkp_idx];
  assign lkp_hi = hi_mem[lkp_idx];
  assign rd_hit = win_sel;
  assign rd_val = upper ? hi_mem[wn] : lo_mem[wn];
endmodule

// File: rtl/obx_xlat_core.sv
module obx_xlat_core
  import obx_pkg::*;
#(
  parameter int          LA_W        = 32,
  parameter int          NUM_WIN     = 8,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [LA_W-1:0]  req_addr,
  input  logic             xlat_en,
  input  logic [2:0]       size_idx,
  output logic [IDX_W-1:0] lkp_idx,
  input  logic [31:0]      lkp_lo,
  input  logic [31:0]      lkp_hi,
  output logic             out_valid,
  output logic [63:0]      out_addr,
  output logic             out_miss
);
  logic [31:0] a32, rel, win_num, mask;
  logic [4:0]  shamt;
  logic        below, in_range, hit;
  logic [63:0] xaddr;

  assign a32      = 32'(req_addr);
  assign below    = a32 < REGION_BASE;
  assign rel      = a32 - REGION_BASE;
  assign shamt    = 5'(MB_SHIFT) + {2'b00, size_idx};
  assign win_num  = rel >> shamt;
  assign mask     = (32'h1 << shamt) - 32'h1;
  assign in_range = !below && (win_num < 32'(NUM_WIN));
  assign lkp_idx  = win_num[IDX_W-1:0];
  assign hit      = in_range && lkp_lo[0];
  assign xaddr    = {lkp_hi, lkp_lo[31:1], 1'b0} + {32'h0, rel & mask};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_miss  <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        if (!xlat_en) begin
          out_addr <= {32'h0, a32};
          out_miss <= 1'b0;
        end else if (hit) begin
          out_addr <= xaddr;
          out_miss <= 1'b0;
        end else begin
          out_addr <= '0;
          out_miss <= 1'b1;
        end
      end
    end
  end

  assert_result_follows_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> out_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !out_valid);
  assert_passthrough_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlat_en) |=> (!out_miss && out_addr == {32'h0, $past(a32)}));
  assert_below_region_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlat_en && a32 < REGION_BASE) |=> (out_miss && out_addr == 64'h0));
endmodule

// File: rtl/obx_top.sv
module obx_top
  import obx_pkg::*;
#(
  parameter int          LA_W        = 32,
  parameter int          NUM_WIN     = 8,
  parameter logic [31:0] REGION_BASE = 32'h4000_0000,
  localparam int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  output logic              reg_ready,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_addr,
  output logic              out_valid,
  output logic [63:0]       out_addr,
  output logic              out_miss,
  output logic [7:0]        cfg_bus,
  output logic [4:0]        cfg_dev,
  output logic [2:0]        cfg_func,
  output logic              cfg_type1,
  output logic              link_train_en
);
  logic             wr_en;
  logic             xlat_en;
  logic [2:0]       size_idx;
  cfg_route_t       route;
  logic             c_hit, w_hit;
  logic [31:0]      c_val, w_val;
  logic [IDX_W-1:0] lkp_idx;
  logic [31:0]      lkp_lo, lkp_hi;

  assign reg_ready = 1'b1;
  assign wr_en     = reg_valid && reg_we;

  obx_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .xlat_en(xlat_en), .link_en(link_train_en), .size_idx(size_idx), .route(route),
    .rd_hit(c_hit), .rd_val(c_val)
  );

  obx_win_table #(.NUM_WIN(NUM_WIN)) u_tbl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(reg_addr), .wdata(reg_wdata),
    .lkp_idx(lkp_idx), .lkp_lo(lkp_lo), .lkp_hi(lkp_hi),
    .rd_hit(w_hit), .rd_val(w_val)
  );

  obx_xlat_core #(.LA_W(LA_W), .NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) u_core (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .xlat_en(xlat_en), .size_idx(size_idx), .lkp_idx(lkp_idx),
    .lkp_lo(lkp_lo), .lkp_hi(lkp_hi),
    .out_valid(out_valid), .out_addr(out_addr), .out_miss(out_miss)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_valid && !reg_we;
      if (reg_valid && !reg_we)
        rd_data <= c_hit ? c_val : (w_hit ? w_val : 32'h0);
    end
  end

  assign cfg_bus   = route.bus;
  assign cfg_dev   = route.dev;
  assign cfg_func  = route.func;
  assign cfg_type1 = route.type1;

  assert_read_returns_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_valid && !reg_we) |=> rd_valid);
  assert_no_read_after_write_R2: assert property (@(posedge clk) disable iff (rst)
    !(reg_valid && !reg_we) |=> !rd_valid);
  assert_route_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !(reg_valid && reg_we && reg_addr == OFS_CFG) |=>
      ($stable(cfg_bus) && $stable(cfg_dev) && $stable(cfg_func) && $stable(cfg_type1)));
endmodule

// File: tb/sim_obx_top.sv
`timescale 1ns/1ps
module sim_obx_top;
  localparam int          NW   = 8;
  localparam logic [31:0] BASE = 32'h4000_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_valid = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, rd_valid;
  logic [31:0] rd_data;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        out_valid, out_miss;
  logic [63:0] out_addr;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic        cfg_type1, link_train_en;

  int checks = 0;
  int errors = 0;

  logic [31:0] sh_cmd, sh_cfg, sh_size;
  logic [31:0] sh_lo [NW];
  logic [31:0] sh_hi [NW];
  logic [63:0] exp_a [$];
  logic        exp_m [$];
  string       exp_t [$];

  always #5 clk = ~clk;

  obx_top #(.LA_W(32), .NUM_WIN(NW), .REGION_BASE(BASE)) u0 (
    .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_ready(reg_ready), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .req_valid(req_valid), .req_addr(req_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_miss(out_miss), .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_func(cfg_func),
    .cfg_type1(cfg_type1), .link_train_en(link_train_en)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void sh_write(input logic [11:0] a, input logic [31:0] d);
    if (a == 12'h004) sh_cmd = d;
    else if (a == 12'h008) sh_cfg = d;
    else if (a == 12'h030) sh_size = {29'b0, d[2:0]};
    else if (a >= 12'h200 && a < 12'h200 + 12'(8*NW) && a[1:0] == 2'b00) begin
      if (a[2]) sh_hi[(a - 12'h200) >> 3] = d;
      else      sh_lo[(a - 12'h200) >> 3] = d;
    end
  endfunction

  function automatic logic [31:0] sh_read(input logic [11:0] a);
    if (a == 12'h004) return sh_cmd;
    if (a == 12'h008) return sh_cfg;
    if (a == 12'h030) return sh_size;
    if (a >= 12'h200 && a < 12'h200 + 12'(8*NW) && a[1:0] == 2'b00)
      return a[2] ? sh_hi[(a - 12'h200) >> 3] : sh_lo[(a - 12'h200) >> 3];
    return 32'h0;
  endfunction

  function automatic void model(input logic [31:0] a, output logic [63:0] ea, output logic em);
    logic [31:0] rel, w, msk;
    int sh;
    ea = '0; em = 1'b1;
    if (!sh_cmd[1]) begin ea = {32'h0, a}; em = 1'b0; return; end
    if (a < BASE) return;
    sh  = 20 + int'(sh_size);
    rel = a - BASE;
    w   = rel >> sh;
    msk = (32'h1 << sh) - 1;
    if (w >= NW) return;
    if (!sh_lo[w][0]) return;
    ea = {sh_hi[w], sh_lo[w] & 32'hFFFF_FFFE} + {32'h0, rel & msk};
    em = 1'b0;
  endfunction

  task automatic push_req(input logic [31:0] a, input string tag);
    logic [63:0] ea; logic em;
    model(a, ea, em);
    exp_a.push_back(ea); exp_m.push_back(em); exp_t.push_back(tag);
    req_valid = 1'b1; req_addr = a;
  endtask

  task automatic send(input logic [31:0] a, input string tag);
    @(negedge clk);
    push_req(a, tag);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    sh_write(a, d);
    @(negedge clk);
    reg_valid = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_valid = 1'b0;
    check({tag, " rd_valid"}, {63'h0, rd_valid}, 64'h1);
    check(tag, {32'h0, rd_data}, {32'h0, sh_read(a)});
  endtask

  // Monitor: compares each result with the oldest expected item.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_a.size() == 0) begin
        checks++; errors++;
        $display("FAIL R8: unexpected result actual %h expected none", out_addr);
      end else begin
        logic [63:0] ea; logic em; string t;
        ea = exp_a.pop_front(); em = exp_m.pop_front(); t = exp_t.pop_front();
        check({t, " addr"}, out_addr, ea);
        check({t, " miss"}, {63'h0, out_miss}, {63'h0, em});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    sh_cmd = 0; sh_cfg = 0; sh_size = 0;
    for (int i = 0; i < NW; i++) begin sh_lo[i] = 0; sh_hi[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    check("R1 link_train_en", {63'h0, link_train_en}, 64'h0);
    check("R1 cfg outputs", {47'h0, cfg_bus, cfg_dev, cfg_func, cfg_type1}, 64'h0);
    check("R2 reg_ready", {63'h0, reg_ready}, 64'h1);
    rd(12'h004, "R1 cmd reads 0");
    rd(12'h208, "R1 window1 low reads 0");
    // R4 passthrough while translation off
    send(32'h4000_1234, "R4 passthrough");
    // program 8 MB windows (index 3)
    wr(12'h030, 32'h3);
    wr(12'h200, 32'h8000_0001); wr(12'h204, 32'h0000_0001);
    wr(12'h208, 32'h1000_0001); wr(12'h20C, 32'h0);
    wr(12'h210, 32'h2000_0000); wr(12'h214, 32'h5);
    wr(12'h004, 32'h0000_0003);
    check("R3 link_train_en set", {63'h0, link_train_en}, 64'h1);
    send(32'h4001_2345, "R6 window0 64-bit base");
    send(32'h4080_0005, "R5 window1 index");
    send(32'h4100_0010, "R7 disabled window");
    send(32'h4400_0000, "R7 window beyond count");
    send(32'h3FFF_FFFC, "R7 below region");
    send(32'h43FF_FFFF, "R6 last byte of window7 disabled");
    // R5 size change to 1 MB: same offset now in window 1
    wr(12'h030, 32'h0);
    send(32'h4010_0010, "R5 1MB window1");
    send(32'h4000_0010, "R5 1MB window0");
    // R2 size truncation, unmapped offsets
    wr(12'h030, 32'hFFFF_FFFF);
    rd(12'h030, "R2 size reads 3 bits");
    wr(12'h100, 32'hDEAD_BEEF);
    rd(12'h100, "R2 unmapped reads 0");
    rd(12'h20C, "R2 window1 high readback");
    send(32'h4A00_0004, "R2 unmapped write changed nothing (128MB window1)");
    // R10 config routing
    wr(12'h008, 32'h01AB_1F05);
    check("R10 cfg_bus", {56'h0, cfg_bus}, 64'hAB);
    check("R10 cfg_dev", {59'h0, cfg_dev}, 64'h1F);
    check("R10 cfg_func", {61'h0, cfg_func}, 64'h5);
    check("R10 cfg_type1", {63'h0, cfg_type1}, 64'h1);
    rd(12'h008, "R10 cfg readback");
    send(32'h4000_0000, "R10 request leaves routing");
    check("R10 cfg_bus stable", {56'h0, cfg_bus}, 64'hAB);
    // R9 same-edge write uses old setting
    wr(12'h030, 32'h3);
    @(negedge clk);
    push_req(32'h4000_0100, "R9 same-edge write sees old");
    reg_valid = 1'b1; reg_we = 1'b1; reg_addr = 12'h200; reg_wdata = 32'h7000_0001;
    @(negedge clk);
    sh_write(12'h200, 32'h7000_0001);
    reg_valid = 1'b0; reg_we = 1'b0;
    push_req(32'h4000_0100, "R9 next-edge request sees new");
    @(negedge clk);
    req_valid = 1'b0;
    // R3 clearing translate bit keeps link bit when rewritten
    wr(12'h004, 32'h0000_0001);
    check("R3 link bit kept", {63'h0, link_train_en}, 64'h1);
    send(32'h4000_0100, "R3 translate off passthrough");
    rd(12'h004, "R3 cmd readback");
    repeat (4) @(negedge clk);
    check("R8 all results seen", 64'(exp_a.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule